// File: doc/BRIEF.md
# First-Fault Gather Load Controller

This block carries out one gather load as a series of single-element memory reads. A command brings a governing predicate and one address per lane. The controller visits the active lanes in order from the lowest index to the highest. For each active lane it sends one read on a request/response memory port and stores the returned element in that lane of a result vector. Inactive lanes get no read and hold zero in the result.

A memory fault never becomes an exception. The controller clears the bits of a status mask from the faulting lane upward, issues no further reads and finishes the load. Software can then read the mask, learn how far the load got, and restart from the faulting lane. A separate initialise pulse sets every mask bit true. Each load ends with a one-cycle done pulse, and the result and the mask are final when that pulse is seen.

The command and both memory channels use valid/ready handshakes. A command is accepted only while the block is idle. A request holds its valid and address until the memory raises ready. The block asks for a response only while exactly one read is outstanding. The initialise, done and status pins are plain level signals.

Top module: `ffgather_top`

## Requirements
- R1: After reset the status mask is all ones, the result vector is zero, done is low, the command channel is ready and no memory request is valid.
- R2: Reads are issued one at a time, in ascending lane order, one read per active lane, using that lane's address from the command.
- R3: A lane whose predicate bit is 0 gets no read, cannot fault, and reads as zero in the result.
- R4: An active lane whose response has no fault gets the response data in result bits [lane*DW +: DW], and its status bit is left unchanged.
- R5: On the first faulting response at lane k, status bits k and above are cleared, bits below k are left unchanged, no further reads are issued, and result lanes k and above read zero. Outside an initialise, no status bit ever goes from 0 to 1.
- R6: Each accepted command produces exactly one done pulse, one cycle wide, in the cycle after the last response or the last lane scan. When done is high the block is idle, and the result and mask are final.
- R7: An initialise pulse while idle sets all status bits to 1 on the next clock. An initialise pulse while a load is in progress has no effect.
- R8: The lane-0 flag output always equals status mask bit 0.
- R9: A memory request keeps valid high and its address stable until ready is seen. Response ready is raised only while a read is outstanding, and never in the same cycle as a request valid.
- R10: The command channel drops ready in the cycle after a command is accepted and raises it again once the load has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Set all status bits true (honoured when idle) |
| cmd_valid_i | input | 1 | Load command valid |
| cmd_ready_o | output | 1 | Block idle, command can be taken |
| cmd_pred_i | input | LANES | Governing predicate, bit i for lane i |
| cmd_addr_i | input | LANES*AW | Lane addresses, lane i at [i*AW +: AW] |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | AW | Read address |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_ready_o | output | 1 | Block takes response |
| mem_rsp_data_i | input | DW | Response data |
| mem_rsp_fault_i | input | 1 | Response is a fault |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | LANES*DW | Result vector, lane i at [i*DW +: DW] |
| status_mask_o | output | LANES | Fault status mask |
| status_first_o | output | 1 | Status bit of lane 0 |

## Verification
The properties assume that the memory returns a response only after it has accepted a request, and that the command fields stay stable while a command is valid. The bench's memory model starts a response countdown only at a request handshake, and it holds response valid only until that one response is taken. Commands are driven for a single cycle while the block is idle, so they are accepted at once. The sweep covers every predicate of a four-lane build with each possible fault lane and the no-fault case. Ready and latency patterns vary from load to load. Initialise pulses are placed both while idle and in the middle of loads.

// File: rtl/ffg_pkg.sv
package ffg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ffg_state_e;

  function automatic int lane_bits(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

  function automatic int idx_bits(input int lanes);
    return $clog2(lanes + 1);
  endfunction

endpackage

// File: rtl/ffg_lane_pick.sv
module ffg_lane_pick #(
  parameter int LANES = 4,
  parameter int LW    = 2,
  parameter int IW    = 3
) (
  input  logic [LANES-1:0] pred_i,
  input  logic [IW-1:0]    from_i,
  output logic             found_o,
  output logic [LW-1:0]    lane_o
);

  logic [LANES-1:0] cand;

  // A lane is a candidate when it is active and not yet behind the scan point
  for (genvar g = 0; g < LANES; g++) begin : g_cand
    assign cand[g] = pred_i[g] && (IW'(g) >= from_i);
  end

  // Scan from the top down so the lowest candidate wins
  always_comb begin
    found_o = 1'b0;
    lane_o  = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found_o = 1'b1;
        lane_o  = LW'(i);
      end
    end
  end

endmodule

// File: rtl/ffg_status.sv
module ffg_status #(
  parameter int LANES = 4,
  parameter int LW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_en_i,
  input  logic             trunc_en_i,
  input  logic [LW-1:0]    trunc_lane_i,
  output logic [LANES-1:0] mask_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_o[g] <= 1'b1;
      end else if (trunc_en_i && (LW'(g) >= trunc_lane_i)) begin
        mask_o[g] <= 1'b0;
      end else if (init_en_i) begin
        mask_o[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ffg_result.sv
module ffg_result #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int LW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                wr_en_i,
  input  logic [LW-1:0]       wr_lane_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [LANES*DW-1:0] vec_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_o[g*DW +: DW] <= '0;
      end else if (clear_i) begin
        vec_o[g*DW +: DW] <= '0;
      end else if (wr_en_i && (wr_lane_i == LW'(g))) begin
        vec_o[g*DW +: DW] <= wr_data_i;
      end
    end
  end

endmodule

// File: rtl/ffgather_top.sv
module ffgather_top
  import ffg_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_i,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [LANES-1:0]    cmd_pred_i,
  input  logic [LANES*AW-1:0] cmd_addr_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic [AW-1:0]       mem_req_addr_o,
  input  logic                mem_rsp_valid_i,
  output logic                mem_rsp_ready_o,
  input  logic [DW-1:0]       mem_rsp_data_i,
  input  logic                mem_rsp_fault_i,
  output logic                done_o,
  output logic [LANES*DW-1:0] result_o,
  output logic [LANES-1:0]    status_mask_o,
  output logic                status_first_o
);

  localparam int LW = lane_bits(LANES);
  localparam int IW = idx_bits(LANES);

  ffg_state_e          st_q;
  logic [LANES-1:0]    pred_q;
  logic [LANES*AW-1:0] addr_q;
  logic [IW-1:0]       idx_q;
  logic [LW-1:0]       cur_q;
  logic                done_q;

  logic                pick_found;
  logic [LW-1:0]       pick_lane;

  logic cmd_fire, req_fire, rsp_fire;
  logic finish, trunc_en, wr_en;

  ffg_lane_pick #(.LANES(LANES), .LW(LW), .IW(IW)) u_pick (
    .pred_i  (pred_q),
    .from_i  (idx_q),
    .found_o (pick_found),
    .lane_o  (pick_lane)
  );

  assign cmd_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_ISSUE) && pick_found;
  assign mem_req_addr_o  = addr_q[pick_lane*AW +: AW];
  assign mem_rsp_ready_o = (st_q == ST_WAIT);

  assign cmd_fire = cmd_valid_i && cmd_ready_o;
  assign req_fire = mem_req_valid_o && mem_req_ready_i;
  assign rsp_fire = mem_rsp_valid_i && mem_rsp_ready_o;

  assign trunc_en = rsp_fire && mem_rsp_fault_i;
  assign wr_en    = rsp_fire && !mem_rsp_fault_i;
  assign finish   = trunc_en || ((st_q == ST_ISSUE) && !pick_found);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pred_q <= '0;
      addr_q <= '0;
      idx_q  <= '0;
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_fire) begin
            pred_q <= cmd_pred_i;
            addr_q <= cmd_addr_i;
            idx_q  <= '0;
            st_q   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!pick_found) begin
            st_q <= ST_IDLE;
          end else if (req_fire) begin
            cur_q <= pick_lane;
            st_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_fire) begin
            if (mem_rsp_fault_i) begin
              st_q <= ST_IDLE;
            end else begin
              idx_q <= IW'(cur_q) + IW'(1);
              st_q  <= ST_ISSUE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  ffg_status #(.LANES(LANES), .LW(LW)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_en_i    (init_i && cmd_ready_o),
    .trunc_en_i   (trunc_en),
    .trunc_lane_i (cur_q),
    .mask_o       (status_mask_o)
  );

  ffg_result #(.LANES(LANES), .DW(DW), .LW(LW)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (cmd_fire),
    .wr_en_i   (wr_en),
    .wr_lane_i (cur_q),
    .wr_data_i (mem_rsp_data_i),
    .vec_o     (result_o)
  );

  assign done_o         = done_q;
  assign status_first_o = status_mask_o[0];

endmodule

// File: rtl/ffgather_chk.sv
module ffgather_chk #(
  parameter int LANES = 4,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_i,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [AW-1:0]    mem_req_addr_o,
  input logic             mem_rsp_ready_o,
  input logic             done_o,
  input logic [LANES-1:0] status_mask_o
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid_o && mem_rsp_ready_o));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cmd_ready_o);

  // R7
  init_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i && cmd_ready_o |=> &status_mask_o);

  // R5
  mask_no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i |=> ((status_mask_o & ~$past(status_mask_o)) == '0));

endmodule

bind ffgather_top ffgather_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .init_i          (init_i),
  .cmd_valid_i     (cmd_valid_i),
  .cmd_ready_o     (cmd_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_ready_o (mem_rsp_ready_o),
  .done_o          (done_o),
  .status_mask_o   (status_mask_o)
);

// File: tb/sim_ffgather_top.sv
`timescale 1ns/1ps
module sim_ffgather_top;
  localparam int L  = 4;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_ready_o;
  logic [L-1:0] cmd_pred_i = '0;
  logic [L*AW-1:0] cmd_addr_i = '0;
  logic mem_req_valid_o;
  logic mem_req_ready_i = 1'b0;
  logic [AW-1:0] mem_req_addr_o;
  logic mem_rsp_valid_i = 1'b0;
  logic mem_rsp_ready_o;
  logic [DW-1:0] mem_rsp_data_i = '0;
  logic mem_rsp_fault_i = 1'b0;
  logic done_o;
  logic [L*DW-1:0] result_o;
  logic [L-1:0] status_mask_o;
  logic status_first_o;

  int n_tests = 0;
  int n_fail = 0;
  logic [L-1:0] mask_model;

  always #4 clk = ~clk;

  ffgather_top #(.LANES(L), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .init_i(init_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_pred_i(cmd_pred_i), .cmd_addr_i(cmd_addr_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_ready_o(mem_rsp_ready_o),
    .mem_rsp_data_i(mem_rsp_data_i), .mem_rsp_fault_i(mem_rsp_fault_i),
    .done_o(done_o), .result_o(result_o),
    .status_mask_o(status_mask_o), .status_first_o(status_first_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_data(input logic [AW-1:0] a);
    return DW'(a * 5 + 3);
  endfunction

  task automatic run_load(input logic [L-1:0] pred, input int flane,
                          input bit do_init, input int seed);
    logic [L*AW-1:0] addrs;
    logic [L-1:0]    exp_mask;
    logic [L*DW-1:0] exp_res;
    logic [AW-1:0]   exp_addr [L];
    logic [AW-1:0]   got_addr [L];
    logic [AW-1:0]   pend_addr;
    logic [AW-1:0]   hold_addr;
    int exp_n, got_n, rsp_wait;
    bit stopped, pend, seen_done, hold;

    for (int i = 0; i < L; i++) addrs[i*AW +: AW] = AW'(32 + i * 7 + seed * 3);
    exp_mask = do_init ? '1 : mask_model;
    exp_res = '0;
    exp_n = 0;
    stopped = 0;
    for (int i = 0; i < L; i++) begin
      exp_addr[i] = '0;
      got_addr[i] = '0;
    end
    for (int i = 0; i < L; i++) begin
      if (!stopped && pred[i]) begin
        exp_addr[exp_n] = addrs[i*AW +: AW];
        exp_n++;
        if (i == flane) begin
          for (int j = i; j < L; j++) exp_mask[j] = 1'b0;
          stopped = 1;
        end else begin
          exp_res[i*DW +: DW] = mem_data(addrs[i*AW +: AW]);
        end
      end
    end

    if (do_init) begin
      init_i = 1'b1;
      @(negedge clk);
      init_i = 1'b0;
      check(status_mask_o == '1, "R7", "mask after idle init", 64'(status_mask_o), 64'hF);
    end
    cmd_valid_i = 1'b1;
    cmd_pred_i = pred;
    cmd_addr_i = addrs;
    check(cmd_ready_o == 1'b1, "R10", "idle ready", 64'(cmd_ready_o), 64'h1);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    check(cmd_ready_o == 1'b0, "R10", "busy after accept", 64'(cmd_ready_o), 64'h0);
    // R7: initialise pulse in the middle of a load must be ignored
    if (!do_init) init_i = 1'b1;

    got_n = 0;
    pend = 0;
    rsp_wait = 0;
    pend_addr = '0;
    seen_done = 0;
    hold = 0;
    hold_addr = '0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (done_o) begin
        seen_done = 1;
        break;
      end
      if (cyc > 0) init_i = 1'b0;
      if (hold) begin
        check(mem_req_valid_o && mem_req_addr_o == hold_addr, "R9",
              "request held under back-pressure", 64'(mem_req_addr_o), 64'(hold_addr));
      end
      mem_rsp_valid_i = 1'b0;
      mem_rsp_fault_i = 1'b0;
      mem_rsp_data_i = '0;
      if (pend) begin
        if (rsp_wait == 0) begin
          mem_rsp_valid_i = 1'b1;
          if (got_n - 1 >= 0 && pend_addr == addrs[((flane < L) ? flane : 0)*AW +: AW] && flane < L)
            mem_rsp_fault_i = 1'b1;
          else
            mem_rsp_data_i = mem_data(pend_addr);
          if (mem_rsp_ready_o) pend = 0;
        end else begin
          rsp_wait--;
        end
      end
      mem_req_ready_i = ((cyc + seed) % 3) != 0;
      hold = mem_req_valid_o && !mem_req_ready_i;
      hold_addr = mem_req_addr_o;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (got_n < L) got_addr[got_n] = mem_req_addr_o;
        got_n++;
        pend = 1;
        pend_addr = mem_req_addr_o;
        rsp_wait = ((cyc + seed) % 2) + 1;
      end
      @(negedge clk);
    end
    init_i = 1'b0;
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_fault_i = 1'b0;

    check(seen_done, "R6", "done pulse seen", 64'(seen_done), 64'h1);
    check(status_mask_o == exp_mask, "R5", "status mask", 64'(status_mask_o), 64'(exp_mask));
    check(status_first_o == exp_mask[0], "R8", "lane-0 flag", 64'(status_first_o), 64'(exp_mask[0]));
    check(result_o == exp_res, "R4", "result vector (R3 zero lanes)", 64'(result_o), 64'(exp_res));
    check(got_n == exp_n, "R2", "read count", 64'(got_n), 64'(exp_n));
    for (int i = 0; i < L; i++) begin
      if (i < exp_n)
        check(got_addr[i] == exp_addr[i], "R2", "read address order", 64'(got_addr[i]), 64'(exp_addr[i]));
    end
    check(!mem_req_valid_o, "R5", "no read after finish", 64'(mem_req_valid_o), 64'h0);
    @(negedge clk);
    check(done_o == 1'b0, "R6", "done one cycle wide", 64'(done_o), 64'h0);
    check(cmd_ready_o == 1'b1, "R10", "ready after finish", 64'(cmd_ready_o), 64'h1);
    mask_model = exp_mask;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status_mask_o == '1, "R1", "reset mask", 64'(status_mask_o), 64'hF);
    check(result_o == '0, "R1", "reset result", 64'(result_o), 64'h0);
    check(done_o == 1'b0, "R1", "reset done", 64'(done_o), 64'h0);
    check(cmd_ready_o == 1'b1, "R1", "reset ready", 64'(cmd_ready_o), 64'h1);
    check(mem_req_valid_o == 1'b0, "R1", "reset request", 64'(mem_req_valid_o), 64'h0);
    check(status_first_o == 1'b1, "R8", "reset lane-0 flag", 64'(status_first_o), 64'h1);
    mask_model = '1;
    for (int p = 0; p < 16; p++) begin
      for (int f = 0; f <= L; f++) begin
        run_load(L'(p), f, ((p + f) % 3) == 0, p * 5 + f);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule